// File: doc/BRIEF.md
# Asynchronous Byte-Wide SRAM Access Controller

This block sits between a clocked host and an external asynchronous static RAM that holds 524,288 bytes. The host issues single-byte read or write requests over a valid/ready handshake. The controller turns each request into a timed sequence on the memory's active-low chip select, write enable and output enable, and on its 19-bit address. The 8-bit data bus is brought out as separate outgoing data, incoming data and drive-enable signals, so that the pad ring can build the tristate buffer.

All memory timing limits are stored in nanoseconds for two speed grades, a fast one and a slow one. They are turned into clock-cycle counts at elaboration from the clock period parameter. Each count is the limit divided by the period, rounded up, and never less than one cycle. After reset the controller keeps chip select high and refuses requests for a recovery interval of 5 ms, which is a parameter. This gives the memory time to recover after its supply has been restored.

The request side has back-pressure. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. While `req_ready` is low the host must hold its request, and anything it presents is not used. The response side has no back-pressure: `rsp_valid` is a single-cycle pulse that the host must capture.

Top module: `sramc_top`

## Requirements
- R1: After reset, `req_ready` stays low and `mem_cs_n` stays high for exactly ceil(REC_NS/CLK_NS) clock edges. `req_ready` first reads high in the cycle that follows that many rising edges after reset release.
- R2: While no access is in progress, `mem_cs_n`, `mem_we_n` and `mem_oe_n` are all 1, `mem_dq_oe` is 0, and `req_ready` is 1 once R1's interval has passed.
- R3: An accepted write (`req_we`=1) is carried out in three phases, starting the cycle after acceptance. The first phase lasts Cod cycles: chip select low, write enable high, output enable high, bus not driven. The second phase is the pulse: write enable low, with the bus driving the write data. The third phase is one cycle with write enable high and the bus still driven. After that the controller is idle. The address equals the request address throughout.
- R4: For the fast grade (tAA 55, tWP 40, tAW 50, tDW 25, tOD 20, tCYC 55 ns), the pulse lasts max(Cwp, Cdw, Caw−Cod, Ccyc−Cod−1) cycles. Each C is the rounded-up cycle count of the matching limit, and the result is 2 cycles at a 20 ns clock.
- R5: An accepted read (`req_we`=0) holds chip select and output enable low and write enable high for max(Caa, Ccyc) cycles with a stable address. It then returns to idle.
- R6: In the first cycle after a read, `rsp_valid` is 1 for exactly one cycle. In that cycle `rsp_data` holds the bus value present in the last read cycle, and `req_ready` is high again.
- R7: `req_ready` is low from the cycle after acceptance until the access ends. A request presented during that time has no effect on the strobes or on the memory contents.
- R8: `mem_dq_oe` is never 1 while `mem_oe_n` is 0.
- R9: For the slow grade (tAA 70, tWP 50, tAW 60, tDW 30, tOD 25, tCYC 70 ns), the same formulas apply. At a 20 ns clock they give 2 disable cycles, 3 pulse cycles and 4 read cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Byte address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle read-data pulse |
| rsp_data | output | 8 | Captured read data |
| mem_addr | output | 19 | Memory address |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_dq_out | output | 8 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_out` |
| mem_dq_in | input | 8 | Data returned by the memory |

## Verification
The assertions check the following on every cycle: that the bus is never driven against the memory's outputs, that strobes stay quiet while chip select is high, that the address is stable and data driven through the write pulse, that the bus is held after write enable rises, that the response is a single pulse, and that the lockout holds during recovery. The exact number of cycles in each phase, and which cycle the read data is taken from, can only be shown by the bench's scenarios. The bench's memory model presents valid data only in the final read cycle. The bench also shows that a request offered while busy is dropped, that addresses at both ends of the range work, and that the two speed grades give different phase lengths.

// File: rtl/sramc_pkg.sv
package sramc_pkg;

  typedef enum logic [1:0] {
    LIM_AA, LIM_WP, LIM_AW, LIM_DW
  } lim_a_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WDIS, ST_WPUL, ST_WHLD, ST_RD
  } seq_st_e;

  // Nanosecond limits per grade; fast grade first argument
  function automatic int grade_ns(input bit fast, input int which);
    int v;
    case (which)
      0: v = fast ? 55 : 70;  // address access
      1: v = fast ? 40 : 50;  // write pulse
      2: v = fast ? 50 : 60;  // address to write-enable rise
      3: v = fast ? 25 : 30;  // data to write-enable rise
      4: v = fast ? 20 : 25;  // output disable
      default: v = fast ? 55 : 70;  // cycle time
    endcase
    return v;
  endfunction

  function automatic int ns2cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sramc_pwrup.sv
module sramc_pwrup #(
  parameter int CLK_NS = 20,
  parameter int REC_NS = 5_000_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic rec_done
);
  import sramc_pkg::*;

  localparam int REC_C = ns2cyc(REC_NS, CLK_NS);
  localparam int RW    = $clog2(REC_C + 1);

  logic [RW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_q != RW'(REC_C)) cnt_q <= cnt_q + 1'b1;
  end

  assign rec_done = (cnt_q == RW'(REC_C));

endmodule

// File: rtl/sramc_seq.sv
module sramc_seq #(
  parameter int CLK_NS = 20,
  parameter bit FAST   = 1'b1,
  parameter int AW     = 19,
  parameter int DW     = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_cs_n,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  output logic          cap
);
  import sramc_pkg::*;

  localparam int AA_C  = ns2cyc(grade_ns(FAST, 0), CLK_NS);
  localparam int WP_C  = ns2cyc(grade_ns(FAST, 1), CLK_NS);
  localparam int AWH_C = ns2cyc(grade_ns(FAST, 2), CLK_NS);
  localparam int DS_C  = ns2cyc(grade_ns(FAST, 3), CLK_NS);
  localparam int OD_C  = ns2cyc(grade_ns(FAST, 4), CLK_NS);
  localparam int CY_C  = ns2cyc(grade_ns(FAST, 5), CLK_NS);
  localparam int PUL_C = imax(imax(WP_C, DS_C), imax(imax(AWH_C - OD_C, CY_C - OD_C - 1), 1));
  localparam int RD_C  = imax(AA_C, CY_C);
  localparam int CW    = $clog2(imax(imax(PUL_C, RD_C), OD_C) + 1);

  seq_st_e       st_q;
  logic [CW-1:0] cnt_q;
  logic          last;

  assign last      = (cnt_q == '0);
  assign req_ready = enable && (st_q == ST_IDLE);
  assign cap       = (st_q == ST_RD) && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      cnt_q      <= '0;
      mem_addr   <= '0;
      mem_dq_out <= '0;
      mem_cs_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_dq_oe  <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (req_ready && req_valid) begin
          mem_addr   <= req_addr;
          mem_dq_out <= req_wdata;
          mem_cs_n   <= 1'b0;
          if (req_we) begin
            st_q  <= ST_WDIS;
            cnt_q <= CW'(OD_C - 1);
          end else begin
            st_q     <= ST_RD;
            cnt_q    <= CW'(RD_C - 1);
            mem_oe_n <= 1'b0;
          end
        end
        ST_WDIS: if (last) begin
          st_q      <= ST_WPUL;
          cnt_q     <= CW'(PUL_C - 1);
          mem_we_n  <= 1'b0;
          mem_dq_oe <= 1'b1;
        end else cnt_q <= cnt_q - 1'b1;
        ST_WPUL: if (last) begin
          st_q     <= ST_WHLD;
          mem_we_n <= 1'b1;
        end else cnt_q <= cnt_q - 1'b1;
        ST_WHLD: begin
          st_q      <= ST_IDLE;
          mem_cs_n  <= 1'b1;
          mem_dq_oe <= 1'b0;
        end
        ST_RD: if (last) begin
          st_q     <= ST_IDLE;
          mem_cs_n <= 1'b1;
          mem_oe_n <= 1'b1;
        end else cnt_q <= cnt_q - 1'b1;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R2
  quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cs_n |-> (mem_we_n && mem_oe_n && !mem_dq_oe));

  // R3
  pulse_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out) && mem_dq_oe));

  // R3
  hold_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (mem_dq_oe && !mem_cs_n));

  // R7
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

endmodule

// File: rtl/sramc_rdcap.sv
module sramc_rdcap #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap,
  input  logic [DW-1:0] dq_in,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= cap;
      if (cap) rsp_data <= dq_in;
    end
  end

  // R6
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

endmodule

// File: rtl/sramc_top.sv
module sramc_top #(
  parameter int CLK_NS     = 20,
  parameter bit FAST_GRADE = 1'b1,
  parameter int REC_NS     = 5_000_000,
  parameter int ADDR_W     = 19,
  parameter int DATA_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  logic rec_done;
  logic cap;

  sramc_pwrup #(.CLK_NS(CLK_NS), .REC_NS(REC_NS)) u_pwrup (
    .clk(clk), .rst_n(rst_n), .rec_done(rec_done)
  );

  sramc_seq #(.CLK_NS(CLK_NS), .FAST(FAST_GRADE), .AW(ADDR_W), .DW(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .enable(rec_done),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .cap(cap)
  );

  sramc_rdcap #(.DW(DATA_W)) u_rdcap (
    .clk(clk), .rst_n(rst_n), .cap(cap), .dq_in(mem_dq_in),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  // R8
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_dq_oe && !mem_oe_n));

  // R1
  recovery_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rec_done |-> (mem_cs_n && !req_ready));

endmodule

// File: tb/sramc_lane.sv
module sramc_lane #(
  parameter bit FAST   = 1'b1,
  parameter int REC_NS = 1000
) (
  input  logic clk,
  input  logic rst_n,
  output logic done,
  output int   tests,
  output int   fails
);
  localparam int TCK = 20;

  function automatic int cyc(input int ns);
    int c;
    c = (ns + TCK - 1) / TCK;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int AA_C  = cyc(FAST ? 55 : 70);
  localparam int WP_C  = cyc(FAST ? 40 : 50);
  localparam int AWH_C = cyc(FAST ? 50 : 60);
  localparam int DS_C  = cyc(FAST ? 25 : 30);
  localparam int OD_C  = cyc(FAST ? 20 : 25);
  localparam int CY_C  = cyc(FAST ? 55 : 70);
  localparam int PUL_C = mx(mx(WP_C, DS_C), mx(mx(AWH_C - OD_C, CY_C - OD_C - 1), 1));
  localparam int RD_C  = mx(AA_C, CY_C);
  localparam int REC_C = cyc(REC_NS);

  logic        req_valid, req_ready, req_we, rsp_valid;
  logic [18:0] req_addr, mem_addr;
  logic [7:0]  req_wdata, rsp_data, mem_dq_out, mem_dq_in;
  logic        mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;

  sramc_top #(.CLK_NS(TCK), .FAST_GRADE(FAST), .REC_NS(REC_NS)) i_sramc_top (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  // Behavioural memory: 16 cells selected by a small hash of the address
  function automatic int idx(input logic [18:0] a);
    return {a[18], a[2:0]};
  endfunction

  logic [7:0] mem_m   [0:15];
  logic [7:0] mem_ref [0:15];
  int         rd_age;
  logic       rd_act;

  initial for (int i = 0; i < 16; i++) begin mem_m[i] = 8'h00; mem_ref[i] = 8'h00; end

  assign rd_act = !mem_cs_n && !mem_oe_n && mem_we_n;

  always @(posedge clk) begin
    if (rst_n && !mem_cs_n && !mem_we_n) mem_m[idx(mem_addr)] = mem_dq_out;
    rd_age <= rd_act ? rd_age + 1 : 0;
  end

  // data is only valid once the access time has elapsed
  always_comb mem_dq_in = (rd_act && rd_age >= AA_C - 1) ? mem_m[idx(mem_addr)] : 8'hEE;

  task automatic chk(input string r, input string what, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s fast=%0d actual=%0h expected=%0h", r, what, FAST, act, exp);
    end
  endtask

  task automatic frame(input string r, input bit cs, input bit we, input bit oe,
                       input bit dq, input bit rdy);
    chk(r, "strobes{cs,we,oe,dqoe,rdy}",
        {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe, req_ready}, {cs, we, oe, dq, rdy});
    chk("R8", "drive against output", mem_dq_oe & ~mem_oe_n, 0);
  endtask

  task automatic do_write(input logic [18:0] a, input logic [7:0] d, input bit junk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_we = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    if (junk) begin req_addr = 19'h12345; req_wdata = 8'hFF; end
    else req_valid = 1'b0;
    for (int i = 0; i < OD_C; i++) begin
      frame(junk ? "R7" : "R3", 0, 1, 1, 0, 0);
      chk("R3", "addr", mem_addr, a);
      @(negedge clk);
    end
    for (int i = 0; i < PUL_C; i++) begin
      frame(FAST ? "R4" : "R9", 0, 0, 1, 1, 0);
      chk("R3", "addr", mem_addr, a);
      chk("R3", "wdata", mem_dq_out, d);
      @(negedge clk);
    end
    frame("R3", 0, 1, 1, 1, 0);
    chk("R3", "hold wdata", mem_dq_out, d);
    @(negedge clk);
    req_valid = 1'b0;
    frame("R2", 1, 1, 1, 0, 1);
    mem_ref[idx(a)] = d;
  endtask

  task automatic do_read(input logic [18:0] a, input string tag);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_we = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < RD_C; i++) begin
      frame(FAST ? "R5" : "R9", 0, 1, 0, 0, 0);
      chk("R5", "addr", mem_addr, a);
      @(negedge clk);
    end
    frame("R6", 1, 1, 1, 0, 1);
    chk("R6", "rsp_valid", rsp_valid, 1);
    chk(tag, "rsp_data", rsp_data, mem_ref[idx(a)]);
    @(negedge clk);
    chk("R6", "rsp_valid drop", rsp_valid, 0);
    frame("R2", 1, 1, 1, 0, 1);
  endtask

  initial begin
    int first;
    tests = 0; fails = 0; done = 1'b0; first = -1;
    req_valid = 1'b0; req_we = 1'b0; req_addr = '0; req_wdata = '0;
    @(posedge rst_n);
    for (int k = 1; k <= REC_C + 5; k++) begin
      @(negedge clk);
      if (req_ready) begin first = k; break; end
      chk("R1", "cs_n during recovery", mem_cs_n, 1);
    end
    chk("R1", "first ready cycle", first, REC_C);
    for (int i = 0; i < 3; i++) begin
      frame("R2", 1, 1, 1, 0, 1);
      @(negedge clk);
    end
    do_write(19'h00000, 8'h5A, 1'b0);
    do_write(19'h7FFFF, 8'hC3, 1'b0);
    do_write(19'h12345, 8'h11, 1'b0);
    do_read(19'h7FFFF, "R6");
    do_read(19'h00000, "R6");
    do_write(19'h00000, 8'hA7, 1'b1);
    do_read(19'h12345, "R7");
    do_read(19'h00000, "R6");
    do_write(19'h7FFFF, 8'h3C, 1'b0);
    do_read(19'h7FFFF, "R6");
    done = 1'b1;
  end

endmodule

// File: tb/test_sramc_top.sv
module test_sramc_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic done_f, done_s;
  int   t_f, f_f, t_s, f_s;

  always #10 clk = ~clk;

  sramc_lane #(.FAST(1'b1), .REC_NS(1000)) u_fast (
    .clk(clk), .rst_n(rst_n), .done(done_f), .tests(t_f), .fails(f_f)
  );
  sramc_lane #(.FAST(1'b0), .REC_NS(1000)) u_slow (
    .clk(clk), .rst_n(rst_n), .done(done_s), .tests(t_s), .fails(f_s)
  );

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  end

  initial begin
    int extra;
    extra = 0;
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (done_f && done_s) break;
    end
    if (!(done_f && done_s)) begin
      extra = 1;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("[TB] %0d tests run, %0d failed", t_f + t_s + extra, f_f + f_s + extra);
    $finish;
  end
endmodule